// File: doc/BRIEF.md
# Codec Reset Pin Controller

This block owns the active-low reset line of an external audio codec and is controlled through one memory-mapped control word on a simple read/write bus in the system clock domain. Software can drive the pin in either of two ways. In forced mode it writes the pin level directly, and that level stays on the pin until software changes it. In timed mode it requests a one-shot pulse. The hardware then holds the pin low for a fixed number of ticks of a slow reference clock and clears the request by itself.

The slow reference clock reaches the block as a one-cycle tick that is already synchronous to the system clock. A timed request can land anywhere between two ticks, so the pulse lasts between four and five reference periods. Forced mode always wins over a pulse that is running. The pulse keeps counting underneath, though, so turning forced mode off while the pulse is still active shows the remaining low time on the pin.

Top module: `codec_rst_ctrl`

## Requirements
- R1: After a synchronous reset every control bit reads 0, the pin is high and the read data is 0.
- R2: The control word at address REG_ADDR holds three fields. Bit 2 is the force enable, bit 1 is the forced pin level and bit 0 is the timed-pulse request. All other bits read 0 and writes to them are ignored. Read data appears on the clock edge after a read strobe and is 0 when no read is strobed.
- R3: While force enable is 1, the pin takes the value of the forced-level bit one clock after that bit is written.
- R4: While force enable is 0, the forced-level bit has no effect on the pin.
- R5: Force enable has priority over a running timed pulse. Writing 0 to bit 0 while forcing does not cancel the pulse.
- R6: Writing 1 to bit 0 pulls the pin low from the next clock. The bit clears itself on the fifth reference tick after the write, and the pin returns high one clock later.
- R7: Bit 0 reads 1 for as long as the timed pulse runs.
- R8: Writing 1 to bit 0 during a pulse restarts the count, so the pulse then ends five ticks after the second write.
- R9: Writing 0 to bit 0 during a pulse does not shorten it.
- R10: With force enable 0 and no pulse running, the pin is high.
- R11: The pulse counter advances only on reference ticks, so system clocks with no tick do not end the pulse.
- R12: A write to any address other than REG_ADDR changes nothing. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle tick per reference clock period |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| codec_rst_n | output | 1 | Active-low codec reset pin, registered |

## Verification
The bench targets four edge cases. The first is a second request that arrives mid-pulse: a design that ignores it releases the pin too early. The second is a clear of bit 0 mid-pulse: a design that honours it truncates the pulse. The third is long runs of system clocks with no tick: a design that counts clocks instead of ticks ends the pulse after a few cycles. The fourth is turning forcing on and then off again over a running pulse: a design with the wrong priority, or one that resets the pulse when forcing is entered, shows the wrong level on the pin. Random writes, reads, ticks and a reset in mid-run are compared cycle by cycle against a bench model. This catches wrong field positions, reserved bits that leak into read data, and writes decoded at the wrong address.

// File: rtl/crst_pkg.sv
package crst_pkg;
  localparam int unsigned BIT_TIMED  = 0;
  localparam int unsigned BIT_LEVEL  = 1;
  localparam int unsigned BIT_ENABLE = 2;
  localparam int unsigned CTL_BITS   = 3;
endpackage

// File: rtl/crst_regs.sv
module crst_regs
  import crst_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              busy,
  output logic              force_en,
  output logic              force_lvl,
  output logic              start_pulse,
  output logic [DATA_W-1:0] rd_data
);
  logic              hit;
  logic [DATA_W-1:0] rd_word;
  logic              unused_hi;

  assign hit         = (bus_addr == REG_ADDR);
  assign start_pulse = wr_en && hit && wr_data[BIT_TIMED];
  assign unused_hi   = ^wr_data[DATA_W-1:CTL_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      force_en  <= 1'b0;
      force_lvl <= 1'b0;
    end else if (wr_en && hit) begin
      force_en  <= wr_data[BIT_ENABLE];
      force_lvl <= wr_data[BIT_LEVEL];
    end
  end

  always_comb begin
    rd_word             = '0;
    rd_word[BIT_TIMED]  = busy;
    rd_word[BIT_LEVEL]  = force_lvl;
    rd_word[BIT_ENABLE] = force_en;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en && hit)
      rd_data <= rd_word;
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/crst_pulse_timer.sv
module crst_pulse_timer #(
  parameter int unsigned PULSE_TICKS = 5,
  localparam int unsigned CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ref_tick,
  output logic             busy,
  output logic [CNT_W-1:0] tick_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
    end else if (busy && ref_tick) begin
      if (tick_cnt == LAST) begin
        busy     <= 1'b0;
        tick_cnt <= '0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crst_pin_drive.sv
module crst_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic force_en,
  input  logic force_lvl,
  input  logic busy,
  output logic pin_n
);
  always_ff @(posedge clk) begin
    if (rst)
      pin_n <= 1'b1;
    else if (force_en)
      pin_n <= force_lvl;
    else
      pin_n <= !busy;
  end
endmodule

// File: rtl/codec_rst_ctrl.sv
module codec_rst_ctrl #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA0,
  parameter int unsigned PULSE_TICKS = 5,
  localparam int unsigned CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              codec_rst_n
);
  logic             force_en;
  logic             force_lvl;
  logic             start_pulse;
  logic             busy;
  logic [CNT_W-1:0] tick_cnt;

  crst_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .busy(busy),
    .force_en(force_en), .force_lvl(force_lvl),
    .start_pulse(start_pulse), .rd_data(rd_data)
  );

  crst_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(start_pulse), .ref_tick(ref_tick),
    .busy(busy), .tick_cnt(tick_cnt)
  );

  crst_pin_drive u_pin (
    .clk(clk), .rst(rst), .force_en(force_en), .force_lvl(force_lvl),
    .busy(busy), .pin_n(codec_rst_n)
  );
endmodule

// File: rtl/crst_checker.sv
module crst_checker #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA0,
  parameter int unsigned PULSE_TICKS = 5,
  parameter int unsigned CNT_W       = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              force_en,
  input logic              force_lvl,
  input logic              busy,
  input logic [CNT_W-1:0]  tick_cnt,
  input logic              pin
);
  logic start_req;
  assign start_req = wr_en && (bus_addr == REG_ADDR) && wr_data[0];

  // R3: forced level reaches the pin one clock later
  a_r3_forced_follow: assert property (@(posedge clk) disable iff (rst)
    force_en |=> (pin == $past(force_lvl)));

  // R6: a running pulse with forcing off holds the pin low
  a_r6_low_while_busy: assert property (@(posedge clk) disable iff (rst)
    (!force_en && busy) |=> !pin);

  // R10: idle pin is high
  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!force_en && !busy) |=> pin);

  // R8: a request always (re)starts the count from zero
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (busy && tick_cnt == '0));

  // R11: without a tick the pulse neither advances nor ends
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (busy && !ref_tick && !start_req) |=> (busy && $stable(tick_cnt)));

  // R6: count stays inside the pulse length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    32'(tick_cnt) < PULSE_TICKS);
endmodule

bind codec_rst_ctrl crst_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
  .PULSE_TICKS(PULSE_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
  .wr_en(wr_en), .wr_data(wr_data), .force_en(force_en),
  .force_lvl(force_lvl), .busy(busy), .tick_cnt(tick_cnt), .pin(codec_rst_n)
);

// File: tb/codec_rst_ctrl_bench.sv
module codec_rst_ctrl_bench;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] RA = 8'hA0;
  localparam int unsigned TICKS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic [ADDR_W-1:0] bus_addr = RA;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic codec_rst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  codec_rst_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(RA),
                   .PULSE_TICKS(TICKS)) u_codec_rst_ctrl (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .codec_rst_n(codec_rst_n)
  );

  // Bench model built from the requirements
  logic m_fen, m_flvl, m_busy, m_pin;
  int   m_cnt;
  logic [DATA_W-1:0] m_rd;

  function automatic logic [DATA_W-1:0] model_word(logic fen, logic flvl, logic bsy);
    logic [DATA_W-1:0] w = '0;
    w[2] = fen; w[1] = flvl; w[0] = bsy;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fen <= 0; m_flvl <= 0; m_busy <= 0; m_cnt <= 0; m_pin <= 1; m_rd <= '0;
    end else begin
      m_pin <= m_fen ? m_flvl : !m_busy;
      m_rd  <= (rd_en && bus_addr == RA) ? model_word(m_fen, m_flvl, m_busy) : '0;
      if (wr_en && bus_addr == RA) begin
        m_fen  <= wr_data[2];
        m_flvl <= wr_data[1];
      end
      if (wr_en && bus_addr == RA && wr_data[0]) begin
        m_busy <= 1; m_cnt <= 0;
      end else if (m_busy && ref_tick) begin
        if (m_cnt == TICKS - 1) begin m_busy <= 0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done && !rst) begin
      chk(m_fen ? "R3/R5 pin" : (m_busy ? "R6 pin" : "R10 pin"),
          DATA_W'(codec_rst_n), DATA_W'(m_pin));
      chk("R2 rd_data", rd_data, m_rd);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bus_addr = RA;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; bus_addr = RA;
    d = rd_data;
  endtask

  task automatic tick(int n, int gap);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
      cyc(gap);
    end
  endtask

  initial begin
    #(5ns * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] r;
    void'($urandom(32'h5eed_c0de));
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pin after reset", DATA_W'(codec_rst_n), 1);
    rd(RA, r); chk("R1 bits after reset", r, 0);

    // R3 forced level
    wr(RA, 32'h6); cyc(1); chk("R3 forced high", DATA_W'(codec_rst_n), 1);
    wr(RA, 32'h4); cyc(1); chk("R3 forced low", DATA_W'(codec_rst_n), 0);
    // R4 level ignored without enable
    wr(RA, 32'h2); cyc(1); chk("R4 level ignored", DATA_W'(codec_rst_n), 1);
    rd(RA, r); chk("R2 fields readback", r, 32'h2);
    // R2 reserved bits
    wr(RA, 32'hFFFF_FFF8); rd(RA, r); chk("R2 reserved read 0", r, 0);

    // R6 / R7 / R11 timed pulse
    wr(RA, 32'h1); cyc(1); chk("R6 pulse low", DATA_W'(codec_rst_n), 0);
    rd(RA, r); chk("R7 busy reads 1", r, 1);
    tick(4, 2);
    cyc(30); chk("R11 no tick no end", DATA_W'(codec_rst_n), 0);
    tick(1, 1); chk("R6 pin high after 5th tick", DATA_W'(codec_rst_n), 1);
    rd(RA, r); chk("R6 self-clear", r, 0);

    // R8 restart
    wr(RA, 32'h1); tick(3, 1);
    wr(RA, 32'h1); tick(4, 1);
    chk("R8 still low after restart", DATA_W'(codec_rst_n), 0);
    tick(1, 1); chk("R8 ends 5 ticks after rewrite", DATA_W'(codec_rst_n), 1);

    // R9 writing 0 does not cancel
    wr(RA, 32'h1); tick(2, 1);
    wr(RA, 32'h0); cyc(3);
    chk("R9 pulse kept", DATA_W'(codec_rst_n), 0);
    tick(3, 1); chk("R9 ends on schedule", DATA_W'(codec_rst_n), 1);

    // R5 priority
    wr(RA, 32'h1); wr(RA, 32'h6); cyc(1);
    chk("R5 force over pulse", DATA_W'(codec_rst_n), 1);
    rd(RA, r); chk("R5 pulse still running", r, 32'h7);
    wr(RA, 32'h2); cyc(1);
    chk("R5 pulse visible after unforce", DATA_W'(codec_rst_n), 0);
    tick(5, 1); chk("R10 idle high", DATA_W'(codec_rst_n), 1);

    // R12 other address
    wr(8'h10, 32'h4); cyc(1);
    chk("R12 foreign write ignored", DATA_W'(codec_rst_n), 1);
    wr(RA, 32'h6); rd(8'h10, r); chk("R12 foreign read 0", r, 0);
    wr(RA, 32'h0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) rst = 1'b1;
      if (i == 2002) rst = 1'b0;
      ref_tick = ($urandom_range(0, 5) == 0);
      bus_addr = ($urandom_range(0, 7) == 0) ? 8'($urandom) : RA;
      wr_en    = ($urandom_range(0, 9) == 0);
      wr_data  = $urandom;
      if (wr_data[2] && $urandom_range(0, 2) != 0) wr_data[2] = 1'b0;
      rd_en    = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0; ref_tick = 0;
    cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule